// File: doc/BRIEF.md
# ADC Shared Conversion Clock Generator

This block makes the conversion clock that several analog-to-digital converters share. It outputs the clock as a one-cycle enable pulse in the bus clock domain. A single control word sets it up. The word is reached through a simple register port at byte address 8. It holds a two-bit source/mode selector, a four-bit prescaler code and three free-running analog channel enables: internal reference, temperature sensor and battery monitor.

In the kernel mode the pulse train is derived from a kernel tick input. That input stands for edges of an asynchronous kernel clock, so the clock mux is modelled as an enable select. The tick is divided by a ratio taken from a non-power-of-two table. In the three bus modes every bus cycle counts as a source tick, and the divider runs at 1, 2 or 4 while the prescaler is ignored. Each converter reports six activity bits. While any of them is high, the clock-shaping fields cannot be changed, but the channel enables still can.

Top module: `adc_shared_clkgen`

## Requirements
- R1: After synchronous reset the control word reads 0. This means kernel mode, prescaler code 0 (divide by 1) and all channel enables clear. With a kernel tick every cycle, `conv_ce` is then high every cycle.
- R2: The control word sits only at byte address 8. Bits 17:16 are the mode, bits 21:18 the prescaler code and bits 24:22 the channel enables (bit 22 reference, bit 23 temperature, bit 24 battery). All other bits read 0 and ignore writes. Reads at any other address return 0, and writes there change nothing.
- R3: In mode 0, `conv_ce` pulses once every N kernel ticks. Prescaler codes 0..11 give N = 1, 2, 4, 6, 8, 10, 12, 16, 32, 64, 128, 256.
- R4: Modes 1, 2 and 3 pulse once every 1, 2 and 4 bus cycles. The prescaler code has no effect on them.
- R5: Prescaler codes 12..15 divide by 1 in mode 0. They read back as the value that was written.
- R6: A write to address 8 while any bit of `act_bits` is 1 leaves the mode and prescaler fields unchanged.
- R7: The channel enables take the written value on every write to address 8, whether or not any converter is active.
- R8: Each `conv_ce` pulse lasts one cycle and follows a source tick. Successive pulses under a fixed setting are exactly N source ticks apart.
- R9: A change of mode or effective ratio restarts the divider count from 0. In a bus mode the first new pulse is high in the (N+1)th cycle after the write edge.
- R10: `reg_rdata` is registered. It shows a written value one cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ker_tick | input | 1 | One-cycle marker of a kernel clock edge |
| act_bits | input | NUM_ADC*6 | Per-converter activity bits: calibrate, injected start, regular start, stop, disable, enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered readback for the current address |
| conv_ce | output | 1 | Conversion clock enable pulse |

## Verification
The assertions assume that `ker_tick`, `act_bits` and the register inputs are steady around each rising edge. They also assume that a write is a single-cycle strobe with address and data valid alongside it. The bench drives every input one nanosecond after a rising edge and holds it for the whole cycle. It clears `act_bits` before any setting whose pulse spacing it measures, so the divider is never reconfigured in the middle of a measurement. The kernel tick comes from a fixed-period generator, and its period is changed only between measurements.

// File: rtl/adc_clkgen_pkg.sv
package adc_clkgen_pkg;

  // Field placement inside the control word
  localparam int unsigned CKM_LSB     = 16;
  localparam int unsigned CKM_W       = 2;
  localparam int unsigned PSC_LSB     = 18;
  localparam int unsigned PSC_W       = 4;
  localparam int unsigned EN_LSB      = 22;
  localparam int unsigned NUM_EN      = 3;
  localparam int unsigned ACT_PER_ADC = 6;
  localparam int unsigned RATIO_W     = 9;

  typedef enum logic [CKM_W-1:0] {
    CKM_KER  = 2'd0,
    CKM_BUS1 = 2'd1,
    CKM_BUS2 = 2'd2,
    CKM_BUS4 = 2'd3
  } ckm_e;

  // Kernel-path division ratio; reserved codes fall back to 1
  function automatic logic [RATIO_W-1:0] psc_ratio(input logic [PSC_W-1:0] code);
    logic [RATIO_W-1:0] r;
    case (code)
      4'd0:    r = 9'd1;
      4'd1:    r = 9'd2;
      4'd2:    r = 9'd4;
      4'd3:    r = 9'd6;
      4'd4:    r = 9'd8;
      4'd5:    r = 9'd10;
      4'd6:    r = 9'd12;
      4'd7:    r = 9'd16;
      4'd8:    r = 9'd32;
      4'd9:    r = 9'd64;
      4'd10:   r = 9'd128;
      4'd11:   r = 9'd256;
      default: r = 9'd1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/adc_ccr_regs.sv
module adc_ccr_regs
  import adc_clkgen_pkg::*;
#(
  parameter int unsigned NUM_ADC  = 2,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CCR_ADDR = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [NUM_ADC*ACT_PER_ADC-1:0] act,
  output ckm_e                           ckm,
  output logic [PSC_W-1:0]               psc,
  output logic [NUM_EN-1:0]              chan_en
);

  logic [NUM_ADC-1:0] adc_busy;
  logic               any_busy;
  logic               hit;

  // One activity reduction per converter
  for (genvar g = 0; g < NUM_ADC; g++) begin : g_busy
    assign adc_busy[g] = |act[g*ACT_PER_ADC +: ACT_PER_ADC];
  end

  assign any_busy = |adc_busy;
  assign hit      = wr && (addr == ADDR_W'(CCR_ADDR));

  always_ff @(posedge clk) begin
    if (rst) begin
      ckm     <= CKM_KER;
      psc     <= '0;
      chan_en <= '0;
    end else if (hit) begin
      chan_en <= wdata[EN_LSB +: NUM_EN];
      if (!any_busy) begin
        ckm <= ckm_e'(wdata[CKM_LSB +: CKM_W]);
        psc <= wdata[PSC_LSB +: PSC_W];
      end
    end
  end

endmodule

// File: rtl/adc_ratio_sel.sv
module adc_ratio_sel
  import adc_clkgen_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  ckm_e             ckm,
  input  logic [PSC_W-1:0] psc,
  input  logic             ker_tick,
  output logic [CNT_W-1:0] ratio_m1,
  output logic             src_tick
);

  logic [RATIO_W-1:0] ratio;
  logic [CKM_W-1:0]   mcode;

  assign mcode = ckm;

  always_comb begin
    if (ckm == CKM_KER) begin
      ratio    = psc_ratio(psc);
      src_tick = ker_tick;
    end else begin
      ratio    = RATIO_W'(1) << (mcode - 2'd1);
      src_tick = 1'b1;
    end
    ratio_m1 = CNT_W'(ratio - RATIO_W'(1));
  end

endmodule

// File: rtl/adc_tick_div.sv
module adc_tick_div #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned KEY_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_tick,
  input  logic [CNT_W-1:0] ratio_m1,
  input  logic [KEY_W-1:0] cfg_key,
  output logic             ce
);

  logic [CNT_W-1:0] cnt;
  logic [KEY_W-1:0] key_q;
  logic             restart;
  logic             wrap;

  assign restart = (cfg_key != key_q);
  assign wrap    = (cnt == ratio_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      key_q <= '0;
      ce    <= 1'b0;
    end else begin
      key_q <= cfg_key;
      ce    <= !restart && src_tick && wrap;
      if (restart)
        cnt <= '0;
      else if (src_tick)
        cnt <= wrap ? '0 : cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/adc_shared_clkgen.sv
module adc_shared_clkgen
  import adc_clkgen_pkg::*;
#(
  parameter int unsigned NUM_ADC   = 2,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CCR_ADDR  = 8,
  parameter int unsigned MAX_RATIO = 256
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           ker_tick,
  input  logic [NUM_ADC*ACT_PER_ADC-1:0] act_bits,
  input  logic                           reg_wr,
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic [DATA_W-1:0]              reg_wdata,
  output logic [DATA_W-1:0]              reg_rdata,
  output logic                           conv_ce
);

  localparam int unsigned CNT_W = $clog2(MAX_RATIO);
  localparam int unsigned KEY_W = CKM_W + CNT_W;

  ckm_e              ckm;
  logic [PSC_W-1:0]  psc;
  logic [NUM_EN-1:0] chan_en;
  logic [CNT_W-1:0]  ratio_m1;
  logic              src_tick;
  logic [DATA_W-1:0] ccr_word;

  adc_ccr_regs #(
    .NUM_ADC (NUM_ADC),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CCR_ADDR(CCR_ADDR)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .act    (act_bits),
    .ckm    (ckm),
    .psc    (psc),
    .chan_en(chan_en)
  );

  adc_ratio_sel #(
    .CNT_W(CNT_W)
  ) u_sel (
    .ckm     (ckm),
    .psc     (psc),
    .ker_tick(ker_tick),
    .ratio_m1(ratio_m1),
    .src_tick(src_tick)
  );

  adc_tick_div #(
    .CNT_W(CNT_W),
    .KEY_W(KEY_W)
  ) u_div (
    .clk     (clk),
    .rst     (rst),
    .src_tick(src_tick),
    .ratio_m1(ratio_m1),
    .cfg_key ({ckm, ratio_m1}),
    .ce      (conv_ce)
  );

  always_comb begin
    ccr_word                      = '0;
    ccr_word[CKM_LSB +: CKM_W]    = ckm;
    ccr_word[PSC_LSB +: PSC_W]    = psc;
    ccr_word[EN_LSB  +: NUM_EN]   = chan_en;
  end

  always_ff @(posedge clk) begin
    if (rst)
      reg_rdata <= '0;
    else
      reg_rdata <= (reg_addr == ADDR_W'(CCR_ADDR)) ? ccr_word : '0;
  end

endmodule

// File: rtl/adc_shared_clkgen_chk.sv
module adc_shared_clkgen_chk
  import adc_clkgen_pkg::*;
#(
  parameter int unsigned NUM_ADC  = 2,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CCR_ADDR = 8
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           ker_tick,
  input logic [NUM_ADC*ACT_PER_ADC-1:0] act_bits,
  input logic                           reg_wr,
  input logic [ADDR_W-1:0]              reg_addr,
  input logic [DATA_W-1:0]              reg_wdata,
  input logic [DATA_W-1:0]              reg_rdata,
  input logic                           conv_ce,
  input logic [DATA_W-1:0]              ccr_word
);

  logic ccr_hit;
  assign ccr_hit = reg_wr && (reg_addr == ADDR_W'(CCR_ADDR));

  // R6: clock fields frozen while any converter is active
  p_lockout_r6: assert property (@(posedge clk) disable iff (rst)
    (ccr_hit && |act_bits) |=> $stable(ccr_word[21:16]));

  // R7: enables always follow a write
  p_enables_r7: assert property (@(posedge clk) disable iff (rst)
    ccr_hit |=> (ccr_word[24:22] == $past(reg_wdata[24:22])));

  // R2: writes elsewhere do nothing
  p_other_addr_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !ccr_hit) |=> $stable(ccr_word));

  // R2: unimplemented bits read 0
  p_unused_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[31:25] == 7'd0) && (reg_rdata[15:0] == 16'd0));

  // R8: every pulse follows a source tick
  p_ce_src_r8: assert property (@(posedge clk) disable iff (rst)
    conv_ce |-> $past(ker_tick || (ccr_word[17:16] != 2'd0)));

  // R4: settled bus divide-by-1 pulses every cycle
  p_bus_div1_r4: assert property (@(posedge clk) disable iff (rst)
    ((ccr_word[17:16] == 2'd1) && ($past(ccr_word[17:16]) == 2'd1)
      && ($past(ccr_word[17:16], 2) == 2'd1)) |-> conv_ce);

endmodule

bind adc_shared_clkgen adc_shared_clkgen_chk #(
  .NUM_ADC (NUM_ADC),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .CCR_ADDR(CCR_ADDR)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .ker_tick (ker_tick),
  .act_bits (act_bits),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .conv_ce  (conv_ce),
  .ccr_word (ccr_word)
);

// File: tb/adc_shared_clkgen_tb_top.sv
`timescale 1ns/1ps
module adc_shared_clkgen_tb_top;

  localparam int NUM_ADC = 2;
  localparam int ACT_W   = NUM_ADC * 6;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ker_tick = 1'b0;
  logic [ACT_W-1:0] act_bits = '0;
  logic             reg_wr = 1'b0;
  logic [7:0]       reg_addr = 8'd8;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic             conv_ce;

  adc_shared_clkgen dut_i (
    .clk(clk), .rst(rst), .ker_tick(ker_tick), .act_bits(act_bits),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .conv_ce(conv_ce)
  );

  always #4 clk = ~clk;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  longint cyc = 0;
  int    ker_per = 1;
  int    ker_ph = 0;
  bit    arm = 1'b0;
  bit    last_valid = 1'b0;
  longint last_cyc = 0;
  int    exp_q[$];
  string cur_tag = "";

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ker_ratio(input int code);
    int t[12] = '{1, 2, 4, 6, 8, 10, 12, 16, 32, 64, 128, 256};
    return (code < 12) ? t[code] : 1;
  endfunction

  function automatic logic [31:0] cfg(input int mode, input int code, input int en);
    return (32'(mode) << 16) | (32'(code) << 18) | (32'(en) << 22);
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // kernel tick generator
  initial begin
    forever begin
      @(posedge clk); #1;
      ker_tick = (ker_ph == 0);
      ker_ph = (ker_ph + 1 >= ker_per) ? 0 : ker_ph + 1;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (arm && conv_ce) begin
      if (last_valid && exp_q.size() > 0) begin
        automatic int e = exp_q.pop_front();
        chk((cyc - last_cyc) == e, cur_tag, cyc - last_cyc, e);
      end
      last_cyc = cyc;
      last_valid = 1'b1;
    end
  end

  task automatic write_reg(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_addr = 8'd8;
  endtask

  task automatic read_reg(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    @(posedge clk); #1;
    d = reg_rdata;
    reg_addr = 8'd8;
  endtask

  // driver: program, check restart latency, push expected gaps
  task automatic run_cfg(input logic [31:0] d, input int gap, input int npulse,
                         input int lat_exp, input string tag);
    int lat;
    arm = 1'b0; last_valid = 1'b0; exp_q.delete(); cur_tag = tag;
    write_reg(8'd8, d);
    lat = 0;
    for (int i = 1; i < 5000; i++) begin
      @(posedge clk); #1;
      if (conv_ce) begin lat = i; break; end
    end
    if (lat_exp > 0) chk(lat == lat_exp, "R9 first pulse latency", lat, lat_exp);
    else chk(lat > 0, {tag, " first pulse"}, lat, 1);
    arm = 1'b1;
    for (int k = 0; k < npulse; k++) exp_q.push_back(gap);
    for (int w = 0; w < gap * (npulse + 2) + 20; w++) begin
      if (exp_q.size() == 0) break;
      @(posedge clk); #1;
    end
    chk(exp_q.size() == 0, {tag, " pulses missing"}, exp_q.size(), 0);
    arm = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    // R1: reset state
    read_reg(8'd8, rd);
    chk(rd == 32'h0, "R1 reset readback", rd, 0);
    repeat (3) @(posedge clk); #1;
    chk(conv_ce == 1'b1, "R1 kernel div1 after reset", conv_ce, 1);

    // R2/R10: field mask and registered readback
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = 8'd8; reg_wdata = 32'hFFFF_FFFF;
    @(posedge clk); #1;
    reg_wr = 1'b0;
    chk(reg_rdata == 32'h0, "R10 readback not yet updated", reg_rdata, 0);
    @(posedge clk); #1;
    chk(reg_rdata == 32'h01FF_0000, "R10 R2 readback mask", reg_rdata, 32'h01FF_0000);

    // R2: other addresses
    write_reg(8'd4, 32'h0);
    read_reg(8'd8, rd);
    chk(rd == 32'h01FF_0000, "R2 write elsewhere ignored", rd, 32'h01FF_0000);
    read_reg(8'd4, rd);
    chk(rd == 32'h0, "R2 other address reads 0", rd, 0);

    // R4/R9: bus modes, prescaler ignored
    run_cfg(cfg(1, 0, 0), 1, 6, 2, "R4 bus div1");
    run_cfg(cfg(2, 8, 0), 2, 5, 3, "R4 bus div2 psc ignored");
    run_cfg(cfg(3, 11, 0), 4, 5, 5, "R4 bus div4 psc ignored");

    // R3/R8: kernel table, tick every cycle
    ker_per = 1;
    for (int c = 0; c < 12; c++)
      run_cfg(cfg(0, c, 0), ker_ratio(c), 3, 0, "R3 kernel ratio");
    // R8: spaced kernel ticks
    ker_per = 3;
    run_cfg(cfg(0, 3, 0), 18, 3, 0, "R8 kernel div6 tick/3");
    run_cfg(cfg(0, 6, 0), 36, 3, 0, "R8 kernel div12 tick/3");

    // R5: reserved code
    ker_per = 2;
    run_cfg(cfg(0, 13, 0), 2, 4, 0, "R5 reserved acts as div1");
    read_reg(8'd8, rd);
    chk(rd == cfg(0, 13, 0), "R5 reserved code reads back", rd, cfg(0, 13, 0));

    // R6/R7: lockout while busy
    ker_per = 1;
    write_reg(8'd8, cfg(2, 5, 0));
    act_bits = 12'h200;
    write_reg(8'd8, cfg(3, 9, 5));
    read_reg(8'd8, rd);
    chk(rd == cfg(2, 5, 5), "R6 R7 blocked write", rd, cfg(2, 5, 5));
    act_bits = 12'h001;
    write_reg(8'd8, cfg(0, 2, 2));
    read_reg(8'd8, rd);
    chk(rd == cfg(2, 5, 2), "R6 R7 blocked write conv0", rd, cfg(2, 5, 2));
    act_bits = '0;
    run_cfg(cfg(2, 5, 2), 2, 4, 0, "R6 divider unchanged after lockout");
    run_cfg(cfg(1, 0, 7), 1, 4, 0, "R6 write accepted when idle");
    read_reg(8'd8, rd);
    chk(rd == cfg(1, 0, 7), "R7 enables set when idle", rd, cfg(1, 0, 7));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule